// File: doc/BRIEF.md
# Hashed-Tag Selective Translation Flush

This block keeps a flop-based shadow of the tags of a set-associative page-table cache. It holds one entry for each set and way. Each entry stores a valid bit, a global bit and three short hashes: one of the address-space identifier, one of the virtual-machine identifier and one of the virtual page number. The refill path writes an entry when the cache fills a way. The block hashes the incoming tags itself.

A fence request carries a kind, a page operand, an address-space operand and a machine operand. In one cycle, every entry is compared with the hashed operands in parallel. On the next clock edge, only the matching entries lose their valid bit. The data arrays read the valid vector to qualify hits. Because the tags are hashed, two different tags can give the same hash. Such a collision can only make a fence clear more entries than needed. It can never let a stale entry survive.

Top module: `tlbf_tag_shadow`

## Requirements
- R1: While reset is low, and right after it is released, every bit of `valid_vec` is 0.
- R2: A refill write with `wr_en` high stores the hashed tags and `wr_global` at index `wr_set*WAYS + wr_way`. On the next edge, bit `wr_set*WAYS + wr_way` of `valid_vec` becomes 1. The entry's bit is then cleared only if R10 applies.
- R3: A fence clears, on the next edge, the valid bit of every valid entry that matches. All other bits keep their value. A fence never sets a valid bit.
- R4: Page operand `fence_vpn` equal to 0 matches any page. Any other value matches only when its hash equals the stored page hash. The hash is an XOR-fold: the operand is split into `HASH_W`-bit chunks starting at bit 0, the top chunk is padded with zeros, and the chunks are XORed together.
- R5: An identifier operand (`fence_asid` or `fence_vmid`) equal to 0 matches any identifier. Any other value is compared with the stored identifier hash, built by the same fold as in R4.
- R6: Kind 0 (supervisor) compares the page and the address-space identifier, and ignores the machine identifier. When `fence_asid` is not zero, entries with the global bit set are never cleared. Kind 3 behaves exactly like kind 0.
- R7: Kind 1 (hypervisor virtual) compares the page, the address-space identifier and the machine identifier. Global entries are protected in the same way as in R6.
- R8: Kind 2 (guest-physical) compares the page and the machine identifier. It ignores both the address-space identifier and the global bit.
- R9: Two different page numbers with the same fold both count as matches, so both entries are cleared.
- R10: When a refill write and a fence arrive in the same cycle, the fence is checked against the incoming tags. If they match, the written entry ends invalid. If they do not match, it ends valid.
- R11: `fence_ready` is always 1, so every fence is accepted in the cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Refill write strobe |
| wr_set | input | $clog2(SETS) | Set of the written entry |
| wr_way | input | $clog2(WAYS) | Way of the written entry |
| wr_vpn | input | VPN_W | Page number of the refill |
| wr_asid | input | ASID_W | Address-space identifier of the refill |
| wr_vmid | input | VMID_W | Machine identifier of the refill |
| wr_global | input | 1 | Global bit of the refill |
| fence_valid | input | 1 | Fence request |
| fence_kind | input | 2 | 0/3 supervisor, 1 hypervisor virtual, 2 guest-physical |
| fence_vpn | input | VPN_W | Page operand, 0 means any |
| fence_asid | input | ASID_W | Address-space operand, 0 means any |
| fence_vmid | input | VMID_W | Machine operand, 0 means any |
| fence_ready | output | 1 | Fence accept, always high |
| valid_vec | output | SETS*WAYS | Valid bit of each entry, index set*WAYS+way |

## Verification
Some properties are checked on every cycle. A refill write sets the bit it addresses. A fence alone never raises a valid bit. An idle cycle leaves the vector unchanged. A global entry survives any supervisor fence that names an identifier. Other behaviour can only be shown by the bench's scenarios: the wildcard rules, the per-kind choice of which tags are compared, the over-flush on a hash collision, and a write that meets a fence in the same cycle. The bench checks these against a model of the requirements.

// File: rtl/tlbf_pkg.sv
package tlbf_pkg;
    typedef enum logic [1:0] {
        FK_SUP    = 2'd0,
        FK_HVIRT  = 2'd1,
        FK_HGUEST = 2'd2,
        FK_SUP_B  = 2'd3
    } fence_kind_e;
endpackage

// File: rtl/tlbf_hash.sv
module tlbf_hash #(
    parameter int IN_W  = 38,
    parameter int OUT_W = 8
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout
);
    localparam int CHUNKS = (IN_W + OUT_W - 1) / OUT_W;
    localparam int PAD_W  = CHUNKS * OUT_W;

    logic [PAD_W-1:0] padded;

    always_comb begin
        padded = '0;
        padded[IN_W-1:0] = din;
        dout = '0;
        for (int c = 0; c < CHUNKS; c++) begin
            dout = dout ^ padded[c*OUT_W +: OUT_W];
        end
    end
endmodule

// File: rtl/tlbf_fence_prep.sv
module tlbf_fence_prep #(
    parameter int VPN_W  = 38,
    parameter int ASID_W = 16,
    parameter int VMID_W = 14,
    parameter int HASH_W = 8
) (
    input  logic [VPN_W-1:0]  vpn,
    input  logic [ASID_W-1:0] asid,
    input  logic [VMID_W-1:0] vmid,
    output logic [HASH_W-1:0] vpn_h,
    output logic [HASH_W-1:0] asid_h,
    output logic [HASH_W-1:0] vmid_h,
    output logic              vpn_any,
    output logic              asid_any,
    output logic              vmid_any
);
    tlbf_hash #(.IN_W(VPN_W),  .OUT_W(HASH_W)) u_h_vpn  (.din(vpn),  .dout(vpn_h));
    tlbf_hash #(.IN_W(ASID_W), .OUT_W(HASH_W)) u_h_asid (.din(asid), .dout(asid_h));
    tlbf_hash #(.IN_W(VMID_W), .OUT_W(HASH_W)) u_h_vmid (.din(vmid), .dout(vmid_h));

    assign vpn_any  = (vpn  == '0);
    assign asid_any = (asid == '0);
    assign vmid_any = (vmid == '0);
endmodule

// File: rtl/tlbf_match.sv
module tlbf_match
    import tlbf_pkg::*;
#(
    parameter int HASH_W = 8
) (
    input  logic              ent_valid,
    input  logic              ent_glob,
    input  logic [HASH_W-1:0] ent_vpn_h,
    input  logic [HASH_W-1:0] ent_asid_h,
    input  logic [HASH_W-1:0] ent_vmid_h,
    input  fence_kind_e       kind,
    input  logic [HASH_W-1:0] op_vpn_h,
    input  logic [HASH_W-1:0] op_asid_h,
    input  logic [HASH_W-1:0] op_vmid_h,
    input  logic              op_vpn_any,
    input  logic              op_asid_any,
    input  logic              op_vmid_any,
    output logic              hit
);
    logic page_ok, asid_ok, vmid_ok, use_asid, use_vmid, honor_glob;

    always_comb begin
        use_asid   = (kind != FK_HGUEST);
        use_vmid   = (kind == FK_HVIRT) || (kind == FK_HGUEST);
        honor_glob = (kind != FK_HGUEST);
        page_ok = op_vpn_any || (ent_vpn_h == op_vpn_h);
        asid_ok = !use_asid || op_asid_any ||
                  ((ent_asid_h == op_asid_h) && !(honor_glob && ent_glob));
        vmid_ok = !use_vmid || op_vmid_any || (ent_vmid_h == op_vmid_h);
        hit = ent_valid && page_ok && asid_ok && vmid_ok;
    end
endmodule

// File: rtl/tlbf_tag_shadow.sv
module tlbf_tag_shadow
    import tlbf_pkg::*;
#(
    parameter int SETS   = 32,
    parameter int WAYS   = 4,
    parameter int VPN_W  = 38,
    parameter int ASID_W = 16,
    parameter int VMID_W = 14,
    parameter int HASH_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [$clog2(SETS)-1:0]    wr_set,
    input  logic [$clog2(WAYS)-1:0]    wr_way,
    input  logic [VPN_W-1:0]           wr_vpn,
    input  logic [ASID_W-1:0]          wr_asid,
    input  logic [VMID_W-1:0]          wr_vmid,
    input  logic                       wr_global,
    input  logic                       fence_valid,
    input  logic [1:0]                 fence_kind,
    input  logic [VPN_W-1:0]           fence_vpn,
    input  logic [ASID_W-1:0]          fence_asid,
    input  logic [VMID_W-1:0]          fence_vmid,
    output logic                       fence_ready,
    output logic [SETS*WAYS-1:0]       valid_vec
);
    localparam int N     = SETS * WAYS;
    localparam int IDX_W = $clog2(N);

    typedef struct packed {
        logic              valid;
        logic              glob;
        logic [HASH_W-1:0] vpn_h;
        logic [HASH_W-1:0] asid_h;
        logic [HASH_W-1:0] vmid_h;
    } entry_t;

    typedef struct packed {
        entry_t [N-1:0] ent;
    } state_t;

    state_t st_d, st_q;

    fence_kind_e       kind;
    logic              fence_fire;
    logic [IDX_W-1:0]  wr_ptr;
    logic [HASH_W-1:0] op_vpn_h, op_asid_h, op_vmid_h;
    logic              op_vpn_any, op_asid_any, op_vmid_any;
    logic [HASH_W-1:0] in_vpn_h, in_asid_h, in_vmid_h;
    logic              in_hit;
    logic [N-1:0]      old_hit;

    assign kind        = fence_kind_e'(fence_kind);
    assign fence_ready = 1'b1;
    assign fence_fire  = fence_valid && fence_ready;
    assign wr_ptr      = IDX_W'(wr_set) * IDX_W'(WAYS) + IDX_W'(wr_way);

    tlbf_fence_prep #(
        .VPN_W(VPN_W), .ASID_W(ASID_W), .VMID_W(VMID_W), .HASH_W(HASH_W)
    ) u_prep (
        .vpn(fence_vpn), .asid(fence_asid), .vmid(fence_vmid),
        .vpn_h(op_vpn_h), .asid_h(op_asid_h), .vmid_h(op_vmid_h),
        .vpn_any(op_vpn_any), .asid_any(op_asid_any), .vmid_any(op_vmid_any)
    );

    tlbf_hash #(.IN_W(VPN_W),  .OUT_W(HASH_W)) u_w_vpn  (.din(wr_vpn),  .dout(in_vpn_h));
    tlbf_hash #(.IN_W(ASID_W), .OUT_W(HASH_W)) u_w_asid (.din(wr_asid), .dout(in_asid_h));
    tlbf_hash #(.IN_W(VMID_W), .OUT_W(HASH_W)) u_w_vmid (.din(wr_vmid), .dout(in_vmid_h));

    tlbf_match #(.HASH_W(HASH_W)) u_in_match (
        .ent_valid(1'b1), .ent_glob(wr_global),
        .ent_vpn_h(in_vpn_h), .ent_asid_h(in_asid_h), .ent_vmid_h(in_vmid_h),
        .kind(kind),
        .op_vpn_h(op_vpn_h), .op_asid_h(op_asid_h), .op_vmid_h(op_vmid_h),
        .op_vpn_any(op_vpn_any), .op_asid_any(op_asid_any), .op_vmid_any(op_vmid_any),
        .hit(in_hit)
    );

    for (genvar i = 0; i < N; i++) begin : g_ent
        tlbf_match #(.HASH_W(HASH_W)) u_match (
            .ent_valid(st_q.ent[i].valid), .ent_glob(st_q.ent[i].glob),
            .ent_vpn_h(st_q.ent[i].vpn_h), .ent_asid_h(st_q.ent[i].asid_h),
            .ent_vmid_h(st_q.ent[i].vmid_h),
            .kind(kind),
            .op_vpn_h(op_vpn_h), .op_asid_h(op_asid_h), .op_vmid_h(op_vmid_h),
            .op_vpn_any(op_vpn_any), .op_asid_any(op_asid_any), .op_vmid_any(op_vmid_any),
            .hit(old_hit[i])
        );

        assign valid_vec[i] = st_q.ent[i].valid;

        // R6: a global entry survives a supervisor fence naming an identifier
        a_r6_global_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (fence_valid && (fence_kind == 2'd0) && (fence_asid != '0) &&
             st_q.ent[i].valid && st_q.ent[i].glob &&
             !(wr_en && (wr_ptr == IDX_W'(i))))
            |=> valid_vec[i]);
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (wr_en && (wr_ptr == IDX_W'(i))) begin
                st_d.ent[i].glob   = wr_global;
                st_d.ent[i].vpn_h  = in_vpn_h;
                st_d.ent[i].asid_h = in_asid_h;
                st_d.ent[i].vmid_h = in_vmid_h;
                st_d.ent[i].valid  = !(fence_fire && in_hit);
            end else if (fence_fire && old_hit[i]) begin
                st_d.ent[i].valid = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: a write with no fence leaves its entry valid
    a_r2_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !fence_valid) |=> valid_vec[$past(wr_ptr)]);

    // R3: a fence alone never raises a valid bit
    a_r3_no_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (fence_valid && !wr_en) |=> ((valid_vec & ~$past(valid_vec)) == '0));

    // R3: with neither write nor fence the vector holds
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!fence_valid && !wr_en) |=> $stable(valid_vec));
endmodule

// File: tb/tlbf_tag_shadow_tb.sv
module tlbf_tag_shadow_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SETS = 32, WAYS = 4, VPN_W = 38, ASID_W = 16, VMID_W = 14, HASH_W = 8;
    localparam int N = SETS * WAYS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [$clog2(SETS)-1:0] wr_set = '0;
    logic [$clog2(WAYS)-1:0] wr_way = '0;
    logic [VPN_W-1:0]  wr_vpn = '0;
    logic [ASID_W-1:0] wr_asid = '0;
    logic [VMID_W-1:0] wr_vmid = '0;
    logic wr_global = 1'b0;
    logic fence_valid = 1'b0;
    logic [1:0] fence_kind = '0;
    logic [VPN_W-1:0]  fence_vpn = '0;
    logic [ASID_W-1:0] fence_asid = '0;
    logic [VMID_W-1:0] fence_vmid = '0;
    logic fence_ready;
    logic [N-1:0] valid_vec;

    int checks = 0;
    int errors = 0;

    logic [N-1:0] exp_q[$];
    string        tag_q[$];

    logic [N-1:0]      m_valid;
    logic [N-1:0]      m_glob;
    logic [HASH_W-1:0] m_vpn[N];
    logic [HASH_W-1:0] m_asid[N];
    logic [HASH_W-1:0] m_vmid[N];

    always #(CLK_PERIOD/2) clk = ~clk;

    tlbf_tag_shadow #(
        .SETS(SETS), .WAYS(WAYS), .VPN_W(VPN_W), .ASID_W(ASID_W),
        .VMID_W(VMID_W), .HASH_W(HASH_W)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_set(wr_set), .wr_way(wr_way),
        .wr_vpn(wr_vpn), .wr_asid(wr_asid), .wr_vmid(wr_vmid), .wr_global(wr_global),
        .fence_valid(fence_valid), .fence_kind(fence_kind), .fence_vpn(fence_vpn),
        .fence_asid(fence_asid), .fence_vmid(fence_vmid), .fence_ready(fence_ready),
        .valid_vec(valid_vec)
    );

    function automatic logic [HASH_W-1:0] fold(input logic [63:0] v, input int w);
        logic [HASH_W-1:0] h = '0;
        for (int b = 0; b < w; b++) h[b % HASH_W] = h[b % HASH_W] ^ v[b];
        return h;
    endfunction

    // Model of the matching rules from R4..R8
    function automatic logic model_hit(input logic gl, input logic [HASH_W-1:0] ev,
            input logic [HASH_W-1:0] ea, input logic [HASH_W-1:0] em, input logic [1:0] k,
            input logic [63:0] fv, input logic [63:0] fa, input logic [63:0] fm);
        logic pg, as, vm;
        pg = (fv == 0) || (ev == fold(fv, VPN_W));
        if (k == 2'd2) as = 1'b1;
        else as = (fa == 0) || (ea == fold(fa, ASID_W) && !gl);
        if (k == 2'd1 || k == 2'd2) vm = (fm == 0) || (em == fold(fm, VMID_W));
        else vm = 1'b1;
        return pg && as && vm;
    endfunction

    task automatic op(input logic we, input int set, input int way, input logic [63:0] vpn,
            input logic [63:0] asid, input logic [63:0] vmid, input logic gl,
            input logic fv, input logic [1:0] k, input logic [63:0] fvpn,
            input logic [63:0] fasid, input logic [63:0] fvmid, input string tag);
        int idx;
        logic [N-1:0] nv;
        @(negedge clk);
        wr_en = we; wr_set = set[$clog2(SETS)-1:0]; wr_way = way[$clog2(WAYS)-1:0];
        wr_vpn = vpn[VPN_W-1:0]; wr_asid = asid[ASID_W-1:0]; wr_vmid = vmid[VMID_W-1:0];
        wr_global = gl; fence_valid = fv; fence_kind = k;
        fence_vpn = fvpn[VPN_W-1:0]; fence_asid = fasid[ASID_W-1:0]; fence_vmid = fvmid[VMID_W-1:0];
        idx = set * WAYS + way;
        nv = m_valid;
        if (fv) begin
            for (int i = 0; i < N; i++)
                if (m_valid[i] && model_hit(m_glob[i], m_vpn[i], m_asid[i], m_vmid[i],
                                            k, fvpn, fasid, fvmid))
                    nv[i] = 1'b0;
        end
        if (we) begin
            m_glob[idx] = gl;
            m_vpn[idx]  = fold(vpn, VPN_W);
            m_asid[idx] = fold(asid, ASID_W);
            m_vmid[idx] = fold(vmid, VMID_W);
            nv[idx] = !(fv && model_hit(gl, m_vpn[idx], m_asid[idx], m_vmid[idx],
                                        k, fvpn, fasid, fvmid));
        end
        m_valid = nv;
        @(posedge clk);
        #1;
        wr_en = 1'b0; fence_valid = 1'b0;
        exp_q.push_back(m_valid);
        tag_q.push_back(tag);
    endtask

    task automatic wr(input int set, input int way, input logic [63:0] vpn,
            input logic [63:0] asid, input logic [63:0] vmid, input logic gl);
        op(1'b1, set, way, vpn, asid, vmid, gl, 1'b0, 2'd0, 0, 0, 0, "R2");
    endtask

    task automatic fence(input logic [1:0] k, input logic [63:0] fvpn,
            input logic [63:0] fasid, input logic [63:0] fvmid, input string tag);
        op(1'b0, 0, 0, 0, 0, 0, 1'b0, 1'b1, k, fvpn, fasid, fvmid, tag);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [N-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (valid_vec !== e) begin
                errors++;
                $display("FAIL %s: valid_vec=%h expected %h", t, valid_vec, e);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_valid = '0; m_glob = '0;
        for (int i = 0; i < N; i++) begin m_vpn[i] = '0; m_asid[i] = '0; m_vmid[i] = '0; end
        repeat (3) @(posedge clk);
        #1;
        exp_q.push_back('0); tag_q.push_back("R1 reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (fence_ready !== 1'b1) begin
            errors++;
            $display("FAIL R11: fence_ready=%b expected 1", fence_ready);
        end

        wr(0, 0, 64'h100, 5, 0, 0);
        wr(0, 1, 64'h100, 6, 0, 1);
        wr(0, 2, 64'h200, 5, 0, 0);
        wr(1, 1, 64'h300, 7, 3, 0);
        wr(2, 1, 64'h300, 7, 4, 1);
        wr(3, 0, 64'h0101, 9, 0, 0);
        wr(3, 1, 64'h10001, 9, 0, 0);
        wr(7, 3, 64'h999, 2, 0, 0);

        fence(2'd0, 64'h100, 0, 0, "R4 page only");
        wr(0, 0, 64'h100, 5, 0, 0);
        wr(0, 1, 64'h100, 6, 0, 1);
        fence(2'd0, 0, 5, 0, "R5 R6 asid only");
        fence(2'd0, 0, 6, 0, "R6 global kept");
        fence(2'd3, 64'h100, 6, 0, "R6 kind3 global kept");
        fence(2'd1, 64'h300, 0, 3, "R7 vmid match");
        fence(2'd1, 0, 7, 4, "R7 global kept");
        fence(2'd2, 0, 0, 4, "R8 ignores global");
        fence(2'd0, 64'h0101, 0, 0, "R9 collision");
        wr(3, 0, 64'h0101, 9, 0, 0);
        fence(2'd0, 64'h0102, 0, 0, "R4 no match");

        op(1'b1, 5, 0, 64'h55, 1, 0, 1'b0, 1'b1, 2'd0, 64'h55, 0, 0, "R10 fence wins");
        op(1'b1, 5, 1, 64'h66, 1, 0, 1'b0, 1'b1, 2'd0, 64'h55, 0, 0, "R10 write lands");

        fence(2'd0, 0, 0, 0, "R3 R5 full wildcard");
        wr(4, 2, 64'h77, 3, 0, 0);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule